// File: doc/BRIEF.md
# One-Hot Four-State Sequence Machine

This block is a small synchronous Moore machine with four states. It uses one flip-flop per state, so exactly one state bit is high at any time. The next value of each flip-flop is the OR of one term per transition arrow that enters its state. A single-bit input `step_in` is sampled on every rising clock edge and picks the transition. The single output `z_out` is high only while the machine sits in its final state.

The four states are called A, B and C (the three approach states) and D (the final state). A run of high inputs moves the machine through A, B, C and then D. A low input in any approach state sends it back to A. Once in D, the machine stays there while the input is low, and a high input returns it to A. The full state vector is also brought out so that the current state can be seen.

The reset is synchronous and active-high. It loads A and clears the other three state bits.

Top module: `onehot_quad_fsm`

## Requirements
- R1: A clock edge with `rst` high loads `state_out` = 4'b0001 and drives `z_out` low. The bit positions are A at bit 0, B at bit 1, C at bit 2 and D at bit 3.
- R2: In state A, a high `step_in` moves to B on the next edge, and a low `step_in` keeps the machine in A.
- R3: In state B, a high `step_in` moves to C, and a low `step_in` moves to A.
- R4: In state C, a high `step_in` moves to D, and a low `step_in` moves to A.
- R5: In state D, a low `step_in` keeps the machine in D, and a high `step_in` moves to A.
- R6: `z_out` is high in exactly the cycles in which `state_out` shows D, and it changes on the same edge as the state.
- R7: After reset, `state_out` has exactly one bit set in every cycle, whatever the input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Transition input, sampled at each rising edge |
| z_out | output | 1 | Registered Moore output, high in state D |
| state_out | output | 4 | One-hot state vector {D,C,B,A} |

## Verification
Every result is due one rising edge after the input that causes it. The state vector and `z_out` both update on the edge that samples `step_in` or `rst`. The driver task applies each input at a falling edge and pushes the state that the requirements predict. The monitor pops that entry one time unit after the next rising edge and compares the state vector, `z_out` and the one-hot property against it. The stimulus covers both input values in every state, a long hold in D, and a reset taken from D.

// File: rtl/onehot_quad_pkg.sv
package onehot_quad_pkg;
  localparam int unsigned NUM_ST = 4;
  localparam int unsigned ST_A = 0;
  localparam int unsigned ST_B = 1;
  localparam int unsigned ST_C = 2;
  localparam int unsigned ST_D = 3;
  localparam logic [NUM_ST-1:0] START_VEC = NUM_ST'(1) << ST_A;
endpackage

// File: rtl/onehot_quad_next.sv
module onehot_quad_next
  import onehot_quad_pkg::*;
(
  input  logic [NUM_ST-1:0] cur,
  input  logic              step,
  output logic [NUM_ST-1:0] nxt
);
  // One term per arrow entering each state, ORed together.
  always_comb begin
    nxt[ST_A] = (cur[ST_A] & ~step) | (cur[ST_B] & ~step)
              | (cur[ST_C] & ~step) | (cur[ST_D] &  step);
    nxt[ST_B] =  cur[ST_A] &  step;
    nxt[ST_C] =  cur[ST_B] &  step;
    nxt[ST_D] = (cur[ST_D] & ~step) | (cur[ST_C] & step);
  end
endmodule

// File: rtl/onehot_quad_bank.sv
module onehot_quad_bank #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // One D flip-flop per state; reset presets or clears each bit separately.
  for (genvar b = 0; b < W; b++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst) q[b] <= INIT[b];
      else     q[b] <= d[b];
    end
  end
endmodule

// File: rtl/onehot_quad_fsm.sv
module onehot_quad_fsm
  import onehot_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_in,
  output logic              z_out,
  output logic [NUM_ST-1:0] state_out
);
  logic [NUM_ST-1:0] cur_st;
  logic [NUM_ST-1:0] nxt_st;

  onehot_quad_next u_next (
    .cur  (cur_st),
    .step (step_in),
    .nxt  (nxt_st)
  );

  onehot_quad_bank #(.W(NUM_ST), .INIT(START_VEC)) u_bank (
    .clk (clk),
    .rst (rst),
    .d   (nxt_st),
    .q   (cur_st)
  );

  // Registered output, loaded from the next value of the final state.
  always_ff @(posedge clk) begin
    if (rst) z_out <= 1'b0;
    else     z_out <= nxt_st[ST_D];
  end

  assign state_out = cur_st;

  AST_RESET_VEC: assert property (@(posedge clk) rst |=> (cur_st == 4'b0001) && !z_out); // R1
  AST_A_STEP: assert property (@(posedge clk) disable iff (rst) (cur_st[ST_A] && step_in) |=> cur_st[ST_B]); // R2
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst) (cur_st[ST_A] && !step_in) |=> cur_st[ST_A]); // R2
  AST_B_MOVE: assert property (@(posedge clk) disable iff (rst) cur_st[ST_B] |=> (step_in ? 1'b0 : 1'b0) || ($past(step_in) ? cur_st[ST_C] : cur_st[ST_A])); // R3
  AST_C_MOVE: assert property (@(posedge clk) disable iff (rst) cur_st[ST_C] |=> ($past(step_in) ? cur_st[ST_D] : cur_st[ST_A])); // R4
  AST_D_MOVE: assert property (@(posedge clk) disable iff (rst) cur_st[ST_D] |=> ($past(step_in) ? cur_st[ST_A] : cur_st[ST_D])); // R5
  AST_Z_TRACKS_D: assert property (@(posedge clk) disable iff (rst) z_out == cur_st[ST_D]); // R6
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $countones(cur_st) == 1); // R7
endmodule

// File: tb/sim_onehot_quad_fsm.sv
module sim_onehot_quad_fsm;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b0;
  logic       z_out;
  logic [3:0] state_out;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_st = 4'b0001;
  logic [3:0] q_st[$];
  string      q_tag[$];
  bit         done = 1'b0;

  onehot_quad_fsm u0 (
    .clk       (clk),
    .rst       (rst),
    .step_in   (step_in),
    .z_out     (z_out),
    .state_out (state_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // Expected next state: A=0001, B=0010, C=0100, D=1000.
  function automatic logic [3:0] model(input logic [3:0] s, input logic v);
    case (s)
      4'b0001: return v ? 4'b0010 : 4'b0001; // R2
      4'b0010: return v ? 4'b0100 : 4'b0001; // R3
      4'b0100: return v ? 4'b1000 : 4'b0001; // R4
      4'b1000: return v ? 4'b0001 : 4'b1000; // R5
      default: return 4'b0001;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_in = 1'b0;
    exp_st = 4'b0001;
    q_st.push_back(exp_st);
    q_tag.push_back("R1");
  endtask

  task automatic drive(input logic v);
    string tag;
    case (exp_st)
      4'b0001: tag = "R2";
      4'b0010: tag = "R3";
      4'b0100: tag = "R4";
      default: tag = "R5";
    endcase
    @(negedge clk);
    rst = 1'b0;
    step_in = v;
    exp_st = model(exp_st, v);
    q_st.push_back(exp_st);
    q_tag.push_back(tag);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: each result is due one rising edge after it was driven.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_st.size() > 0) begin
        logic [3:0] e;
        string t;
        e = q_st.pop_front();
        t = q_tag.pop_front();
        check(t, state_out, e);
        check("R6", z_out, e[3]);
        check("R7", $countones(state_out), 1);
      end
    end
  end

  initial begin
    do_reset();
    drive(1'b0); drive(1'b0);               // A holds
    drive(1'b1); drive(1'b0);               // A->B, B->A
    drive(1'b1); drive(1'b1); drive(1'b0);  // A->B->C, C->A
    drive(1'b1); drive(1'b1); drive(1'b1);  // A->B->C->D
    for (int k = 0; k < 5; k++) drive(1'b0); // D holds
    drive(1'b1);                            // D->A
    drive(1'b1); drive(1'b1); drive(1'b1);  // back to D
    do_reset();                             // reset taken from D
    for (int k = 0; k < 40; k++) drive(((k * 7) % 5) != 0);
    @(negedge clk);
    wait (q_st.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule